// File: doc/BRIEF.md
# Floppy Controller Soft Reset Sequencer

This block owns the host-visible reset path and the main status byte of a floppy disk controller register file. Writes arrive on a small register port that selects either the drive control register or the rate select register. A software reset starts in two ways. The first is a low-to-high change of the reset-release bit in the drive control register. The second is setting the top bit of the rate select register, and while the controller is powered down any write to that register also starts one. A per-variant strap turns the rate-select path off entirely.

A reset does not finish at once. A cycle counter sized from the clock frequency measures a short delay, or a long one when the power-down input is high. At the end the block emits a one-cycle completion event with a code. A normal completion also returns the status byte to its ready value, pulses a clear strobe to the neighbouring command logic, and on non-AT variants forces the data rate field to its default.

The block also loads the status byte when the command logic begins a data transfer phase. The value depends on the direction and on whether the transfer uses DMA. The command decoder, the drive mechanics and the DMA engine sit outside; only their handshake flags enter here.

Top module: `fdc_rst_seq`

## Requirements
- R1: After hardware reset the status byte is 0x80, the rate field is 0, and busy, event valid, DMA request, clear strobe and counter clear strobe are all 0.
- R2: A control-register write (sel=0) whose bit 2 is 1 while the stored bit 2 is 0 raises busy on the next cycle; a write that keeps bit 2 at 1 starts nothing.
- R3: A control-register write with bit 2 at 0 sets the status byte to 0x00 and pulses the counter clear strobe for one cycle.
- R4: With the strap clear, a rate-register write (sel=1) whose bit 7 is 1 while the previously stored bit 7 was 0 starts a reset; while the power-down input is 1, any rate-register write starts a reset.
- R5: With the rate-reset disable strap set, no rate-register write starts a reset or a rate event, and the status byte is left unchanged.
- R6: With the strap clear and power-down low, a rate-register write with bit 7 at 0 schedules a completion event with code 3 after the short delay; it leaves the status byte and the rate field alone.
- R7: A reset started with power-down low completes with code 1 after CLK_MHZ*SHORT_US cycles. One started with power-down high completes with code 2 after CLK_MHZ*LONG_US cycles and changes no status. Event valid is high for exactly one cycle, in the cycle busy falls.
- R8: A code 1 completion sets the status byte to 0x80, clears the DMA request, and pulses the clear strobe and the counter clear strobe in the same cycle as the event.
- R9: A code 1 completion forces the rate field to 2 when the AT strap is 0; with the AT strap at 1 the rate field is kept.
- R10: Every rate-register write copies its bits 1:0 into the rate field on the next cycle.
- R11: A transfer start without DMA sets the status byte to 0xB0 for a host write and to 0x70 for a host read.
- R12: A transfer start with DMA sets the status byte to 0x10 for a host write and 0x50 for a host read, and raises the DMA request. The request stays until the DMA acknowledge, a bit-2-low control write or a code 1 completion.
- R13: A trigger that arrives while a delay is pending restarts the count from the new trigger and replaces the pending code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the drive control register, 1 the rate select register |
| wr_data | input | 8 | Write data |
| pwr_dn | input | 1 | Controller is in power-down |
| cfg_at | input | 1 | AT variant strap: keep the rate field on reset |
| cfg_rate_rst_dis | input | 1 | Strap that disables resets and events from the rate register |
| xfer_start | input | 1 | Pulse from command logic: data transfer phase begins |
| xfer_host_wr | input | 1 | Direction of that transfer: 1 host writes, 0 host reads |
| dma_mode | input | 1 | Transfer uses DMA |
| dma_ack | input | 1 | DMA engine accepted the request |
| msr_o | output | 8 | Main status byte |
| dma_req_o | output | 1 | DMA request |
| rate_o | output | 2 | Data rate field |
| rst_busy_o | output | 1 | A delay is pending |
| evt_valid_o | output | 1 | One-cycle completion event |
| evt_code_o | output | 2 | Event code: 1 reset, 2 powered-down reset, 3 rate event |
| ctrl_clr_o | output | 1 | Strobe telling neighbours to clear ST0, lock, head, step and perpendicular bits 1:0 |
| pcnt_clr_o | output | 1 | Strobe to zero the parameter counters |

## Verification
A stale copy of the stored reset bit or rate top bit shows up one cycle after the next write, as busy rising when it should not, or staying low when it should rise. A counter loaded with the wrong value or not reloaded on retrigger moves the completion event off its exact cycle, and the checks catch this by sampling one cycle before and at the expected edge. A wrong pending code, or wrong completion priority against writes and transfer starts, shows in the status byte, the rate field or the strobes in the cycle the event fires.

// File: rtl/fdc_rst_pkg.sv
package fdc_rst_pkg;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_RESET = 2'd1,
    EV_PDOWN = 2'd2,
    EV_RATE  = 2'd3
  } evt_code_t;

  localparam logic [7:0] MSR_READY = 8'h80;
  localparam logic [7:0] MSR_CLEAR = 8'h00;
  localparam logic [1:0] RATE_DEFAULT = 2'd2;

  // cycles needed for a delay given in microseconds
  function automatic int unsigned us_to_cycles(input int unsigned mhz, input int unsigned us);
    return mhz * us;
  endfunction

  // status byte at the start of a transfer phase
  function automatic logic [7:0] xfer_status(input logic host_wr, input logic dma);
    logic [7:0] s;
    s = host_wr ? 8'h10 : 8'h50;
    if (!dma) begin
      s = s | 8'h20;
      if (host_wr) s = s | 8'h80;
    end
    return s;
  endfunction

endpackage

// File: rtl/fdc_rst_trig.sv
module fdc_rst_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_sel,
  input  logic bit_rel,       // control register bit 2
  input  logic bit_top,       // rate register bit 7
  input  logic pwr_dn,
  input  logic cfg_rate_rst_dis,
  output logic trig_rst,
  output logic trig_rate,
  output logic dor_low_wr,
  output logic dsr_wr
);

  logic rel_q;
  logic top_q;
  logic dor_wr;

  assign dor_wr     = wr_en && !wr_sel;
  assign dsr_wr     = wr_en &&  wr_sel;
  assign dor_low_wr = dor_wr && !bit_rel;

  assign trig_rst = (dor_wr && bit_rel && !rel_q) ||
                    (dsr_wr && !cfg_rate_rst_dis && (pwr_dn || (bit_top && !top_q)));
  assign trig_rate = dsr_wr && !cfg_rate_rst_dis && !bit_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= 1'b0;
      top_q <= 1'b0;
    end else begin
      if (dor_wr) rel_q <= bit_rel;
      if (dsr_wr) top_q <= bit_top;
    end
  end

endmodule

// File: rtl/fdc_rst_timer.sv
module fdc_rst_timer
  import fdc_rst_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned SHORT_US = 8,
  parameter int unsigned LONG_US  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_rst,
  input  logic       trig_rate,
  input  logic       pwr_dn,
  output logic       busy,
  output logic       fire,
  output evt_code_t  fire_code,
  output logic       evt_valid,
  output logic [1:0] evt_code
);

  localparam int unsigned SHORT_CYC = us_to_cycles(CLK_MHZ, SHORT_US);
  localparam int unsigned LONG_CYC  = us_to_cycles(CLK_MHZ, LONG_US);
  localparam int unsigned MAX_CYC   = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int          CW        = $clog2(MAX_CYC) + 1;

  logic [CW-1:0] cnt;
  evt_code_t     pend;
  logic          load;

  assign load      = trig_rst || trig_rate;
  assign fire      = busy && (cnt == '0) && !load;
  assign fire_code = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      busy      <= 1'b0;
      pend      <= EV_NONE;
      evt_valid <= 1'b0;
      evt_code  <= 2'd0;
    end else begin
      evt_valid <= fire;
      if (fire) evt_code <= pend;
      if (trig_rst) begin
        busy <= 1'b1;
        cnt  <= pwr_dn ? CW'(LONG_CYC - 1) : CW'(SHORT_CYC - 1);
        pend <= pwr_dn ? EV_PDOWN : EV_RESET;
      end else if (trig_rate) begin
        busy <= 1'b1;
        cnt  <= CW'(SHORT_CYC - 1);
        pend <= EV_RATE;
      end else if (fire) begin
        busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/fdc_rst_stat.sv
module fdc_rst_stat
  import fdc_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  evt_code_t  fire_code,
  input  logic       dor_low_wr,
  input  logic       dsr_wr,
  input  logic [1:0] rate_field,
  input  logic       xfer_start,
  input  logic       xfer_host_wr,
  input  logic       dma_mode,
  input  logic       dma_ack,
  input  logic       cfg_at,
  output logic [7:0] msr,
  output logic       dma_req,
  output logic [1:0] rate,
  output logic       ctrl_clr,
  output logic       pcnt_clr
);

  logic norm_done;

  assign norm_done = fire && (fire_code == EV_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr      <= MSR_READY;
      dma_req  <= 1'b0;
      rate     <= 2'd0;
      ctrl_clr <= 1'b0;
      pcnt_clr <= 1'b0;
    end else begin
      ctrl_clr <= norm_done;
      pcnt_clr <= norm_done || dor_low_wr;

      if (norm_done)       msr <= MSR_READY;
      else if (dor_low_wr) msr <= MSR_CLEAR;
      else if (xfer_start) msr <= xfer_status(xfer_host_wr, dma_mode);

      if (norm_done || dor_low_wr)   dma_req <= 1'b0;
      else if (xfer_start && dma_mode) dma_req <= 1'b1;
      else if (dma_ack)              dma_req <= 1'b0;

      if (norm_done && !cfg_at) rate <= RATE_DEFAULT;
      else if (dsr_wr)          rate <= rate_field;
    end
  end

endmodule

// File: rtl/fdc_rst_seq.sv
module fdc_rst_seq
  import fdc_rst_pkg::*;
#(
  parameter int unsigned CLK_MHZ  = 100,
  parameter int unsigned SHORT_US = 8,
  parameter int unsigned LONG_US  = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       pwr_dn,
  input  logic       cfg_at,
  input  logic       cfg_rate_rst_dis,
  input  logic       xfer_start,
  input  logic       xfer_host_wr,
  input  logic       dma_mode,
  input  logic       dma_ack,
  output logic [7:0] msr_o,
  output logic       dma_req_o,
  output logic [1:0] rate_o,
  output logic       rst_busy_o,
  output logic       evt_valid_o,
  output logic [1:0] evt_code_o,
  output logic       ctrl_clr_o,
  output logic       pcnt_clr_o
);

  logic      trig_rst;
  logic      trig_rate;
  logic      dor_low_wr;
  logic      dsr_wr;
  logic      tmr_fire;
  evt_code_t tmr_code;

  fdc_rst_trig u_trig (
    .clk              (clk),
    .rst_n            (rst_n),
    .wr_en            (wr_en),
    .wr_sel           (wr_sel),
    .bit_rel          (wr_data[2]),
    .bit_top          (wr_data[7]),
    .pwr_dn           (pwr_dn),
    .cfg_rate_rst_dis (cfg_rate_rst_dis),
    .trig_rst         (trig_rst),
    .trig_rate        (trig_rate),
    .dor_low_wr       (dor_low_wr),
    .dsr_wr           (dsr_wr)
  );

  fdc_rst_timer #(
    .CLK_MHZ  (CLK_MHZ),
    .SHORT_US (SHORT_US),
    .LONG_US  (LONG_US)
  ) u_tmr (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_rst  (trig_rst),
    .trig_rate (trig_rate),
    .pwr_dn    (pwr_dn),
    .busy      (rst_busy_o),
    .fire      (tmr_fire),
    .fire_code (tmr_code),
    .evt_valid (evt_valid_o),
    .evt_code  (evt_code_o)
  );

  fdc_rst_stat u_stat (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (tmr_fire),
    .fire_code    (tmr_code),
    .dor_low_wr   (dor_low_wr),
    .dsr_wr       (dsr_wr),
    .rate_field   (wr_data[1:0]),
    .xfer_start   (xfer_start),
    .xfer_host_wr (xfer_host_wr),
    .dma_mode     (dma_mode),
    .dma_ack      (dma_ack),
    .cfg_at       (cfg_at),
    .msr          (msr_o),
    .dma_req      (dma_req_o),
    .rate         (rate_o),
    .ctrl_clr     (ctrl_clr_o),
    .pcnt_clr     (pcnt_clr_o)
  );

endmodule

// File: rtl/fdc_rst_chk.sv
module fdc_rst_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_sel,
  input logic       bit_rel,
  input logic       cfg_rate_rst_dis,
  input logic       xfer_start,
  input logic       xfer_host_wr,
  input logic       dma_mode,
  input logic       fire,
  input logic [7:0] msr_o,
  input logic       dma_req_o,
  input logic       rst_busy_o,
  input logic       evt_valid_o,
  input logic [1:0] evt_code_o,
  input logic       ctrl_clr_o,
  input logic       pcnt_clr_o
);

  logic rel_sh;
  logic dor_low;

  assign dor_low = wr_en && !wr_sel && !bit_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rel_sh <= 1'b0;
    else if (wr_en && !wr_sel) rel_sh <= bit_rel;
  end

  a_r2_rise_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel && bit_rel && !rel_sh) |=> rst_busy_o);

  a_r3_low_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (dor_low && !fire) |=> (msr_o == 8'h00 && pcnt_clr_o));

  a_r5_rate_path_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rate_rst_dis && wr_en && wr_sel && !rst_busy_o) |=> !rst_busy_o);

  a_r7_event_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_busy_o) |-> evt_valid_o);

  a_r7_event_single: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid_o |=> !evt_valid_o);

  a_r8_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o && evt_code_o == 2'd1) |-> (msr_o == 8'h80 && ctrl_clr_o && pcnt_clr_o && !dma_req_o));

  a_r11_pio_write: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !dma_mode && xfer_host_wr && !fire && !dor_low) |=> msr_o == 8'hB0);

  a_r12_dma_request: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && dma_mode && !fire && !dor_low) |=> dma_req_o);

endmodule

bind fdc_rst_seq fdc_rst_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .wr_en            (wr_en),
  .wr_sel           (wr_sel),
  .bit_rel          (wr_data[2]),
  .cfg_rate_rst_dis (cfg_rate_rst_dis),
  .xfer_start       (xfer_start),
  .xfer_host_wr     (xfer_host_wr),
  .dma_mode         (dma_mode),
  .fire             (tmr_fire),
  .msr_o            (msr_o),
  .dma_req_o        (dma_req_o),
  .rst_busy_o       (rst_busy_o),
  .evt_valid_o      (evt_valid_o),
  .evt_code_o       (evt_code_o),
  .ctrl_clr_o       (ctrl_clr_o),
  .pcnt_clr_o       (pcnt_clr_o)
);

// File: tb/fdc_rst_seq_tb.sv
`timescale 1ns/1ps
module fdc_rst_seq_tb_top;

  localparam int MHZ   = 10;
  localparam int SHORT = MHZ * 8;
  localparam int LONG  = MHZ * 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       pwr_dn = 1'b0, cfg_at = 1'b0, cfg_rate_rst_dis = 1'b0;
  logic       xfer_start = 1'b0, xfer_host_wr = 1'b0, dma_mode = 1'b0, dma_ack = 1'b0;
  logic [7:0] msr_o;
  logic       dma_req_o, rst_busy_o, evt_valid_o, ctrl_clr_o, pcnt_clr_o;
  logic [1:0] rate_o, evt_code_o;

  int n_run  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  fdc_rst_seq #(.CLK_MHZ(MHZ), .SHORT_US(8), .LONG_US(1000)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pwr_dn(pwr_dn), .cfg_at(cfg_at), .cfg_rate_rst_dis(cfg_rate_rst_dis),
    .xfer_start(xfer_start), .xfer_host_wr(xfer_host_wr), .dma_mode(dma_mode),
    .dma_ack(dma_ack), .msr_o(msr_o), .dma_req_o(dma_req_o), .rate_o(rate_o),
    .rst_busy_o(rst_busy_o), .evt_valid_o(evt_valid_o), .evt_code_o(evt_code_o),
    .ctrl_clr_o(ctrl_clr_o), .pcnt_clr_o(pcnt_clr_o)
  );

  // {host_wr, dma, expected dma_req, expected status byte}
  localparam logic [10:0] XFER_VEC [4] = '{
    {1'b1, 1'b0, 1'b0, 8'hB0},
    {1'b0, 1'b0, 1'b0, 8'h70},
    {1'b1, 1'b1, 1'b1, 8'h10},
    {1'b0, 1'b1, 1'b1, 8'h50}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic xfer(input logic host_wr, input logic dma);
    xfer_host_wr = host_wr; dma_mode = dma; xfer_start = 1'b1;
    @(posedge clk); @(negedge clk);
    xfer_start = 1'b0;
  endtask

  // called at the negedge after the trigger edge
  task automatic wait_evt(input int n, input logic [1:0] code, input string req);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk({req, " busy before end"}, rst_busy_o, 1);
    chk({req, " no early event"}, evt_valid_o, 0);
    @(posedge clk); @(negedge clk);
    chk({req, " event"}, evt_valid_o, 1);
    chk({req, " code"}, evt_code_o, code);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 msr", msr_o, 8'h80);
    chk("R1 rate", rate_o, 0);
    chk("R1 busy", rst_busy_o, 0);
    chk("R1 evt", evt_valid_o, 0);
    chk("R1 dma", dma_req_o, 0);
    chk("R1 strobes", {ctrl_clr_o, pcnt_clr_o}, 0);

    // R11 / R12 transfer table
    for (int i = 0; i < 4; i++) begin
      xfer(XFER_VEC[i][10], XFER_VEC[i][9]);
      chk("R11_R12 msr", msr_o, XFER_VEC[i][7:0]);
      chk("R12 dma_req", dma_req_o, XFER_VEC[i][8]);
      if (XFER_VEC[i][9]) begin
        dma_ack = 1'b1; @(posedge clk); @(negedge clk); dma_ack = 1'b0;
        chk("R12 ack clears", dma_req_o, 0);
      end
    end

    // R2 rising release starts a reset; R7/R8/R9 completion
    xfer(1'b1, 1'b1);
    wr(1'b0, 8'h04);
    chk("R2 busy", rst_busy_o, 1);
    wait_evt(SHORT, 2'd1, "R7 short");
    chk("R8 msr", msr_o, 8'h80);
    chk("R8 clr", ctrl_clr_o, 1);
    chk("R8 pcnt", pcnt_clr_o, 1);
    chk("R8 dma", dma_req_o, 0);
    chk("R9 rate forced", rate_o, 2);
    @(negedge clk);
    chk("R7 one cycle", evt_valid_o, 0);

    // R2 held bit does not retrigger
    wr(1'b0, 8'h0C);
    chk("R2 no retrigger", rst_busy_o, 0);

    // R3 low write
    wr(1'b0, 8'h00);
    chk("R3 msr", msr_o, 8'h00);
    chk("R3 pcnt", pcnt_clr_o, 1);

    // R13 restart: release then rate top bit rising 30 cycles later
    wr(1'b0, 8'h04);
    repeat (30) @(posedge clk);
    @(negedge clk);
    wr(1'b1, 8'h80);
    chk("R10 rate copy", rate_o, 0);
    wait_evt(SHORT, 2'd1, "R13 restart");
    chk("R4 rising top msr", msr_o, 8'h80);

    // R4 top bit held: no trigger; R10 copy
    wr(1'b1, 8'h81);
    chk("R4 held top", rst_busy_o, 0);
    chk("R10 rate", rate_o, 1);

    // R6 rate event
    wr(1'b1, 8'h03);
    wait_evt(SHORT, 2'd3, "R6 rate event");
    chk("R6 msr kept", msr_o, 8'h80);
    chk("R6 no clr", ctrl_clr_o, 0);
    chk("R6 rate kept", rate_o, 3);

    // R4 rising top again
    wr(1'b1, 8'h80);
    wait_evt(SHORT, 2'd1, "R4 dsr rise");

    // R7 powered-down reset: any rate write triggers, long delay, no state change
    xfer(1'b1, 1'b0);
    pwr_dn = 1'b1;
    wr(1'b1, 8'h80);
    wait_evt(LONG, 2'd2, "R7 long");
    chk("R7 pd msr kept", msr_o, 8'hB0);
    chk("R7 pd no clr", ctrl_clr_o, 0);
    pwr_dn = 1'b0;

    // R5 strap disables the rate path
    cfg_rate_rst_dis = 1'b1;
    wr(1'b1, 8'h00);
    chk("R5 no rate event", rst_busy_o, 0);
    wr(1'b1, 8'h80);
    chk("R5 no rise trigger", rst_busy_o, 0);
    repeat (SHORT + 5) @(posedge clk);
    @(negedge clk);
    chk("R5 no event", evt_valid_o, 0);
    chk("R5 msr kept", msr_o, 8'hB0);
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h04);
    wait_evt(SHORT, 2'd1, "R5 control path live");
    cfg_rate_rst_dis = 1'b0;

    // R9 AT variant keeps rate
    cfg_at = 1'b1;
    wr(1'b1, 8'h01);
    wait_evt(SHORT, 2'd3, "R9 rate event");
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h04);
    wait_evt(SHORT, 2'd1, "R9 at reset");
    chk("R9 at rate kept", rate_o, 1);

    // R12 low control write drops the DMA request
    xfer(1'b0, 1'b1);
    chk("R12 dma set", dma_req_o, 1);
    wr(1'b0, 8'h00);
    chk("R12 low write clears dma", dma_req_o, 0);
    chk("R3 msr again", msr_o, 8'h00);

    ended = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule